// File: doc/BRIEF.md
# Configurable XOR Bank Index Mapper

This unit turns the word address of a scratchpad access into the index of one of several equally sized banks. The default build has 32 banks, so the index is 5 bits wide. A mode input picks one of three mappings:

- **Plain:** the low address bits are used directly as the index.
- **Fixed hash:** the low 5-bit address field is XORed with the 5-bit field just above it.
- **Configured:** every index bit is the XOR of two address bits, and the pair for each index bit is chosen at run time.

The index is combinational from the address and a set of active registers. The mapping therefore adds no latency on the access path.

A search engine elsewhere writes a candidate selection together with a flag saying whether the search succeeded. The mode input and the candidate are taken into the active registers only on a block-start pulse. Because of this, every thread block sees one consistent mapping from start to finish. A new mapping appears on the output in the cycle after the block-start edge. If the last search failed, the configured mode falls back to the fixed hash.

Top module: `xor_bank_mapper`

## Requirements
- R1: With active mode code 0, the bank index equals addr[4:0].
- R2: With active mode code 1 or 3, the bank index equals addr[4:0] XOR addr[9:5].
- R3: With active mode code 2 and a successful configuration, index bit i equals addr[a] XOR addr[b]. Here a is the select field cfg_sel[8i+3:8i] and b is the select field cfg_sel[8i+7:8i+4].
- R4: After reset, the active mode is the fixed hash and no configuration is held.
- R5: mode_req and a pending configuration have no effect on the index until a blk_start pulse is seen.
- R6: A configuration written while a block runs is held until the next blk_start. It drives the index from the cycle after that blk_start edge, and not before.
- R7: A configuration written with cfg_found low makes mode code 2 behave as the fixed hash.
- R8: A configuration written in the same cycle as blk_start is not used for the block that pulse starts. It is applied at the following blk_start.
- R9: A blk_start with no pending write keeps the previously active configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W (16) | Word address of the access |
| mode_req | input | 2 | Requested mode: 0 plain, 1 or 3 fixed hash, 2 configured |
| blk_start | input | 1 | One-cycle pulse when a new thread block starts |
| cfg_wr | input | 1 | Write strobe for a candidate configuration |
| cfg_found | input | 1 | High when the search found a conflict-free selection |
| cfg_sel | input | 40 | Two 4-bit address-bit selects for each index bit |
| bank | output | 5 | Bank index |

## Verification
The bench builds the block with its default parameters: 32 banks and a 16-bit address. At this size the full address space of 65536 values can be swept under both the plain mapping and the fixed hash. Several computed select patterns are each checked over 4096 addresses. Around the block-start edge, the bench samples the index just before and just after that edge, so the one-cycle switch and the same-cycle write ordering are observed directly.

// File: rtl/xor_bank_mapper.sv
module xor_bank_mapper #(
  parameter int BANKS  = 32,
  parameter int ADDR_W = 16,
  localparam int IDX_W = $clog2(BANKS),
  localparam int SEL_W = $clog2(ADDR_W),
  localparam int CFG_W = 2 * IDX_W * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        mode_req,
  input  logic              blk_start,
  input  logic              cfg_wr,
  input  logic              cfg_found,
  input  logic [CFG_W-1:0]  cfg_sel,
  output logic [IDX_W-1:0]  bank
);

  localparam logic [1:0] M_PLAIN = 2'd0;
  localparam logic [1:0] M_FOLD  = 2'd1;
  localparam logic [1:0] M_CFG   = 2'd2;

  logic [1:0]       act_mode;
  logic             act_ok;
  logic [CFG_W-1:0] act_sel;
  logic             pend_v;
  logic             pend_ok;
  logic [CFG_W-1:0] pend_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_mode <= M_FOLD;
      act_ok   <= 1'b0;
      act_sel  <= '0;
    end else if (blk_start) begin
      act_mode <= mode_req;
      if (pend_v) begin
        act_sel <= pend_sel;
        act_ok  <= pend_ok;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_ok  <= 1'b0;
      pend_sel <= '0;
    end else if (cfg_wr) begin
      pend_v   <= 1'b1;
      pend_ok  <= cfg_found;
      pend_sel <= cfg_sel;
    end else if (blk_start) begin
      pend_v <= 1'b0;
    end
  end

  logic [IDX_W-1:0] lo, hi, fold, pair;
  assign lo   = addr[IDX_W-1:0];
  assign hi   = addr[2*IDX_W-1:IDX_W];
  assign fold = lo ^ hi;

  for (genvar i = 0; i < IDX_W; i++) begin : g_pair
    logic [SEL_W-1:0] sa, sb;
    assign sa      = act_sel[2*i*SEL_W +: SEL_W];
    assign sb      = act_sel[(2*i+1)*SEL_W +: SEL_W];
    assign pair[i] = addr[sa] ^ addr[sb];
  end

  assign bank = (act_mode == M_PLAIN)             ? lo   :
                (act_mode == M_CFG && act_ok)     ? pair : fold;

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_start |=> $stable(act_mode) && $stable(act_sel) && $stable(act_ok));

  assert_pend_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> pend_v);

  assert_consume_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && !cfg_wr) |=> !pend_v);

  assert_apply_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_start && pend_v) |=> act_sel == $past(pend_sel));

  assert_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_mode == M_CFG && !act_ok) |-> ((bank ^ addr[IDX_W-1:0]) == addr[2*IDX_W-1:IDX_W]));

endmodule

// File: tb/sim_xor_bank_mapper.sv
`timescale 1ns/1ps
module sim_xor_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [1:0]  mode_req = 2'd0;
  logic        blk_start = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_found = 1'b0;
  logic [39:0] cfg_sel = '0;
  logic [4:0]  bank;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xor_bank_mapper u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .mode_req(mode_req),
    .blk_start(blk_start), .cfg_wr(cfg_wr), .cfg_found(cfg_found),
    .cfg_sel(cfg_sel), .bank(bank));

  function automatic logic [4:0] pairmap(input logic [15:0] a, input logic [39:0] s);
    logic [4:0] r;
    for (int i = 0; i < 5; i++) r[i] = a[s[8*i +: 4]] ^ a[s[8*i+4 +: 4]];
    return r;
  endfunction

  function automatic logic [39:0] mk_sel(input int k);
    logic [39:0] s;
    for (int i = 0; i < 5; i++) begin
      s[8*i +: 4]   = 4'((i*3 + k) % 16);
      s[8*i+4 +: 4] = 4'((i*5 + 2*k + 7) % 16);
    end
    return s;
  endfunction

  task automatic chk(input string r, input logic [4:0] exp);
    total++;
    if (bank !== exp) begin
      bad++;
      $display("FAIL %s addr=%h bank=%h expected=%h", r, addr, bank, exp);
    end
  endtask

  task automatic pulse(input logic [1:0] m, input bit bs, input bit wr,
                       input bit found, input logic [39:0] s);
    @(negedge clk);
    mode_req = m; blk_start = bs; cfg_wr = wr; cfg_found = found; cfg_sel = s;
    @(negedge clk);
    blk_start = 0; cfg_wr = 0;
  endtask

  task automatic sweep_fold(input string r, input int n);
    for (int a = 0; a < n; a++) begin
      addr = 16'(a * 37 + 5); #1;
      chk(r, addr[4:0] ^ addr[9:5]);
    end
  endtask

  initial begin
    logic [39:0] s1, s2;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep_fold("R4", 256);
    mode_req = 2'd0; #1;
    sweep_fold("R5", 64);

    pulse(2'd0, 1, 0, 0, '0);
    for (int a = 0; a < 65536; a++) begin
      addr = 16'(a); #1; chk("R1", addr[4:0]);
    end
    pulse(2'd1, 1, 0, 0, '0);
    for (int a = 0; a < 65536; a++) begin
      addr = 16'(a); #1; chk("R2", addr[4:0] ^ addr[9:5]);
    end
    pulse(2'd3, 1, 0, 0, '0);
    sweep_fold("R2", 512);

    for (int k = 0; k < 6; k++) begin
      s1 = mk_sel(k);
      pulse(2'd2, 0, 1, 1, s1);
      sweep_fold("R6", 32);
      @(negedge clk);
      mode_req = 2'd2; blk_start = 1; addr = 16'hA5C3; #1;
      chk("R6", addr[4:0] ^ addr[9:5]);
      @(negedge clk);
      blk_start = 0; #1;
      chk("R6", pairmap(addr, s1));
      for (int a = 0; a < 4096; a++) begin
        addr = 16'(a * 16 + a / 7); #1; chk("R3", pairmap(addr, s1));
      end
      pulse(2'd1, 1, 0, 0, '0);
    end

    pulse(2'd2, 0, 1, 0, mk_sel(9));
    pulse(2'd2, 1, 0, 0, '0);
    sweep_fold("R7", 512);

    s1 = mk_sel(3);
    s2 = mk_sel(11);
    pulse(2'd2, 0, 1, 1, s1);
    pulse(2'd2, 1, 0, 0, '0);
    pulse(2'd2, 1, 1, 1, s2);
    for (int a = 0; a < 300; a++) begin
      addr = 16'(a * 211); #1; chk("R8", pairmap(addr, s1));
    end
    pulse(2'd2, 1, 0, 0, '0);
    for (int a = 0; a < 300; a++) begin
      addr = 16'(a * 211); #1; chk("R8", pairmap(addr, s2));
    end
    pulse(2'd2, 1, 0, 0, '0);
    for (int a = 0; a < 300; a++) begin
      addr = 16'(a * 97 + 3); #1; chk("R9", pairmap(addr, s2));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule